// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

The block watches a free-running 64-bit system count supplied from outside and compares it against a 64-bit absolute deadline. Once enabled, if the count reaches the deadline, the block raises a first-stage flag meant for an interrupt. It then moves the deadline forward by one period, so software gets a second window. If that second deadline also passes with no refresh, a second-stage flag is raised. That flag is intended to drive a system reset.

Software uses two independent 32-bit register frames, each with its own write and read strobes. In the kick frame, any write to offset 0x000 refreshes the timer. The control frame holds:
- an enable/status word,
- a 32-bit period,
- the two halves of the deadline.

A refresh loads the deadline with the current count plus the period. Software can also write the deadline halves directly to get waits longer than a 32-bit period allows. Both frames expose two fixed identification words.

Top module: `wdt_escalate`

## Requirements
- R1: After reset the control word, the period and both deadline halves read 0, and both output flags are low.
- R2: The period register at control offset 0x008 stores and returns a 32-bit value.
- R3: An explicit refresh loads the deadline with the system count plus the zero-extended period and clears both stage flags, all on the next clock edge. A write to kick-frame offset 0x000 is an explicit refresh, and the kick frame carries no write data.
- R4: A write to control offset 0x000 sets the enable from data bit 0 and is also an explicit refresh. Reading that offset returns bit 0 = enable, bit 1 = first-stage flag and bit 2 = second-stage flag, with all other bits 0.
- R5: While enabled with the first-stage flag clear, a count at or above the deadline sets the first-stage flag on the next edge. On the same edge the deadline is reloaded to count plus period. A count one below the deadline sets nothing.
- R6: While enabled with the first-stage flag set, a count at or above the deadline sets the second-stage flag. That flag stays set until a refresh or a disable.
- R7: stage1_irq equals enable AND first-stage flag, and stage2_rst equals enable AND second-stage flag.
- R8: Writes to control offsets 0x010 (low half) and 0x014 (high half) replace that half of the deadline from the next cycle on. They leave both stage flags unchanged, and a high half above zero gives a deadline beyond 2^32.
- R9: Offsets 0xFCC and 0xFD0 read the constant words ID_IMPL and ID_PART in both frames.
- R10: Writing 0 to the enable bit stops expiry checking and clears both stage flags.
- R11: When an expiry and an explicit refresh fall in the same cycle, the refresh wins. The flags stay clear and the deadline becomes count plus period.
- R12: Writes to unmapped offsets in either frame have no effect, including kick-frame offsets other than 0x000. Reads of unmapped offsets, and of kick-frame offset 0x000, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | 64 | Free-running system count |
| kick_wr | input | 1 | Kick-frame write strobe |
| kick_rd | input | 1 | Kick-frame read strobe |
| kick_addr | input | ADDR_W | Kick-frame byte offset |
| kick_rdata | output | 32 | Kick-frame read data (combinational, 0 when not reading) |
| ctl_wr | input | 1 | Control-frame write strobe |
| ctl_rd | input | 1 | Control-frame read strobe |
| ctl_addr | input | ADDR_W | Control-frame byte offset |
| ctl_wdata | input | 32 | Control-frame write data |
| ctl_rdata | output | 32 | Control-frame read data (combinational, 0 when not reading) |
| stage1_irq | output | 1 | First-stage timeout level |
| stage2_rst | output | 1 | Second-stage timeout level |

## Verification
The expiry compare and the explicit refresh can land on the same clock edge, and both try to write the deadline and the flags. The bench sets the count exactly equal to the deadline in the same cycle as a kick-frame write. It then reads back the control word and the deadline low half. Both flags must be clear, and the deadline must equal that count plus the period. A direct deadline write that coincides with an expiry is avoided in the stimulus, because the ordering of the halves would make the expected value depend on a reload.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W  = 64;
    localparam int DATA_W = 32;

    // register offsets, byte addressed
    localparam int OFS_CTRL    = 'h000;
    localparam int OFS_PERIOD  = 'h008;
    localparam int OFS_DL_LO   = 'h010;
    localparam int OFS_DL_HI   = 'h014;
    localparam int OFS_ID_IMPL = 'hFCC;
    localparam int OFS_ID_PART = 'hFD0;
    localparam int OFS_KICK    = 'h000;

    // control word bit positions
    localparam int BIT_EN = 0;
    localparam int BIT_S1 = 1;
    localparam int BIT_S2 = 2;

    localparam int FRAME_KICK = 0;
    localparam int FRAME_CTL  = 1;

    typedef struct packed {
        logic              en;
        logic              s1;
        logic              s2;
        logic [DATA_W-1:0] period;
        logic [CNT_W-1:0]  deadline;
    } wdt_state_t;

    typedef struct packed {
        logic refresh;
        logic ctrl;
        logic period;
        logic dl_lo;
        logic dl_hi;
    } wdt_wsel_t;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_PERIOD,
        RSEL_DL_LO,
        RSEL_DL_HI,
        RSEL_ID_IMPL,
        RSEL_ID_PART
    } wdt_rsel_t;

endpackage

// File: rtl/wdt_frame_dec.sv
module wdt_frame_dec
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int FRAME  = FRAME_CTL
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output wdt_wsel_t         wsel,
    output wdt_rsel_t         rsel
);

    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PERIOD  = ADDR_W'(OFS_PERIOD);
    localparam logic [ADDR_W-1:0] A_DL_LO   = ADDR_W'(OFS_DL_LO);
    localparam logic [ADDR_W-1:0] A_DL_HI   = ADDR_W'(OFS_DL_HI);
    localparam logic [ADDR_W-1:0] A_ID_IMPL = ADDR_W'(OFS_ID_IMPL);
    localparam logic [ADDR_W-1:0] A_ID_PART = ADDR_W'(OFS_ID_PART);
    localparam logic [ADDR_W-1:0] A_KICK    = ADDR_W'(OFS_KICK);

    generate
        if (FRAME == FRAME_CTL) begin : g_ctl
            always_comb begin
                wsel         = '0;
                wsel.ctrl    = wr && (addr == A_CTRL);
                wsel.refresh = wr && (addr == A_CTRL);
                wsel.period  = wr && (addr == A_PERIOD);
                wsel.dl_lo   = wr && (addr == A_DL_LO);
                wsel.dl_hi   = wr && (addr == A_DL_HI);
                rsel         = RSEL_NONE;
                if (rd) begin
                    case (addr)
                        A_CTRL:    rsel = RSEL_CTRL;
                        A_PERIOD:  rsel = RSEL_PERIOD;
                        A_DL_LO:   rsel = RSEL_DL_LO;
                        A_DL_HI:   rsel = RSEL_DL_HI;
                        A_ID_IMPL: rsel = RSEL_ID_IMPL;
                        A_ID_PART: rsel = RSEL_ID_PART;
                        default:   rsel = RSEL_NONE;
                    endcase
                end
            end
        end else begin : g_kick
            always_comb begin
                wsel         = '0;
                wsel.refresh = wr && (addr == A_KICK);
                rsel         = RSEL_NONE;
                if (rd) begin
                    case (addr)
                        A_ID_IMPL: rsel = RSEL_ID_IMPL;
                        A_ID_PART: rsel = RSEL_ID_PART;
                        default:   rsel = RSEL_NONE;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdt_deadline.sv
module wdt_deadline
    import wdt_pkg::*;
(
    input  logic              en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  deadline,
    input  logic [DATA_W-1:0] period,
    output logic              hit,
    output logic [CNT_W-1:0]  reload
);

    // next deadline after a refresh or first expiry
    assign reload = cnt + CNT_W'(period);
    // unsigned compare: reaching or passing the deadline counts
    assign hit    = en && (cnt >= deadline);

endmodule

// File: rtl/wdt_state.sv
module wdt_state
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wdt_wsel_t         wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    input  logic [CNT_W-1:0]  reload,
    output wdt_state_t        st_q
);

    wdt_state_t st_d;

    always_comb begin
        st_d = st_q;

        // expiry sequencing: stage one reloads, stage two latches
        if (hit && !st_q.s1) begin
            st_d.s1       = 1'b1;
            st_d.deadline = reload;
        end else if (hit && !st_q.s2) begin
            st_d.s2 = 1'b1;
        end

        if (wsel.period) st_d.period = wdata;
        // direct deadline halves override an expiry reload
        if (wsel.dl_lo) st_d.deadline[DATA_W-1:0]     = wdata;
        if (wsel.dl_hi) st_d.deadline[CNT_W-1:DATA_W] = wdata;
        if (wsel.ctrl)  st_d.en = wdata[BIT_EN];

        // refresh has the last word on flags and deadline
        if (wsel.refresh) begin
            st_d.s1       = 1'b0;
            st_d.s2       = 1'b0;
            st_d.deadline = reload;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
    import wdt_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [31:0] ID_IMPL = 32'h0201_0A57,
    parameter logic [31:0] ID_PART = 32'h0000_0DB2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       sys_cnt,
    input  logic              kick_wr,
    input  logic              kick_rd,
    input  logic [ADDR_W-1:0] kick_addr,
    output logic [31:0]       kick_rdata,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    output logic              stage1_irq,
    output logic              stage2_rst
);

    wdt_wsel_t  kick_wsel, ctl_wsel, wsel;
    wdt_rsel_t  kick_rsel, ctl_rsel;
    wdt_state_t st;
    logic              hit;
    logic [CNT_W-1:0]  reload;

    wdt_frame_dec #(.ADDR_W(ADDR_W), .FRAME(FRAME_KICK)) u_kick_dec (
        .wr(kick_wr), .rd(kick_rd), .addr(kick_addr),
        .wsel(kick_wsel), .rsel(kick_rsel)
    );

    wdt_frame_dec #(.ADDR_W(ADDR_W), .FRAME(FRAME_CTL)) u_ctl_dec (
        .wr(ctl_wr), .rd(ctl_rd), .addr(ctl_addr),
        .wsel(ctl_wsel), .rsel(ctl_rsel)
    );

    assign wsel = kick_wsel | ctl_wsel;

    wdt_deadline u_dl (
        .en(st.en), .cnt(sys_cnt), .deadline(st.deadline),
        .period(st.period), .hit(hit), .reload(reload)
    );

    wdt_state u_state (
        .clk(clk), .rst_n(rst_n), .wsel(wsel), .wdata(ctl_wdata),
        .hit(hit), .reload(reload), .st_q(st)
    );

    function automatic logic [31:0] read_mux(wdt_rsel_t s, wdt_state_t q);
        logic [31:0] v;
        v = '0;
        case (s)
            RSEL_CTRL: begin
                v[BIT_EN] = q.en;
                v[BIT_S1] = q.s1;
                v[BIT_S2] = q.s2;
            end
            RSEL_PERIOD:  v = q.period;
            RSEL_DL_LO:   v = q.deadline[DATA_W-1:0];
            RSEL_DL_HI:   v = q.deadline[CNT_W-1:DATA_W];
            RSEL_ID_IMPL: v = ID_IMPL;
            RSEL_ID_PART: v = ID_PART;
            default:      v = '0;
        endcase
        return v;
    endfunction

    always_comb begin
        ctl_rdata  = read_mux(ctl_rsel, st);
        kick_rdata = read_mux(kick_rsel, st);
    end

    assign stage1_irq = st.en & st.s1;
    assign stage2_rst = st.en & st.s2;

endmodule

// File: rtl/wdt_escalate_chk.sv
module wdt_escalate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] sys_cnt,
    input logic        en,
    input logic        s1,
    input logic        s2,
    input logic [31:0] period,
    input logic [63:0] deadline,
    input logic        refresh,
    input logic        ctrl_wr,
    input logic        dl_lo_wr,
    input logic [31:0] wdata,
    input logic        stage1_irq,
    input logic        stage2_rst
);

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (deadline == $past(sys_cnt) + {32'b0, $past(period)}));

    assert_refresh_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (!s1 && !s2));

    assert_first_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !s1 && (sys_cnt >= deadline) && !refresh) |=> s1);

    assert_s2_needs_s1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s2 |-> s1);

    assert_s2_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s2 && !refresh) |=> s2);

    assert_pins_idle_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!stage1_irq && !stage2_rst));

    assert_dl_lo_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_lo_wr && !refresh) |=> (deadline[31:0] == $past(wdata)));

    assert_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata[0]) |=> (!en && !s1 && !s2));

endmodule

bind wdt_escalate wdt_escalate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
    .en(st.en), .s1(st.s1), .s2(st.s2),
    .period(st.period), .deadline(st.deadline),
    .refresh(wsel.refresh), .ctrl_wr(wsel.ctrl), .dl_lo_wr(wsel.dl_lo),
    .wdata(ctl_wdata), .stage1_irq(stage1_irq), .stage2_rst(stage2_rst)
);

// File: tb/sim_wdt_escalate.sv
module sim_wdt_escalate;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam logic [31:0] IMPL = 32'h0201_0A57;
    localparam logic [31:0] PART = 32'h0000_0DB2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_cnt = '0;
    logic        kick_wr = 0, kick_rd = 0, ctl_wr = 0, ctl_rd = 0;
    logic [11:0] kick_addr = '0, ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] kick_rdata, ctl_rdata;
    logic        stage1_irq, stage2_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_escalate u0 (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
        .kick_wr(kick_wr), .kick_rd(kick_rd), .kick_addr(kick_addr),
        .kick_rdata(kick_rdata),
        .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .stage1_irq(stage1_irq), .stage2_rst(stage2_rst)
    );

    // scoreboard item: kind 0 control read, 1 kick read, 2 output pins
    typedef struct {
        string       req;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    int    n_chk = 0, n_bad = 0;
    logic  pin_chk = 0;
    bit    done = 0;

    // monitor: samples at the falling edge, away from the driving edge
    always @(negedge clk) begin
        if (rst_n && (ctl_rd || kick_rd || pin_chk)) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL scoreboard empty actual=sample expected=item");
            end else begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = ctl_rdata;
                    1:       act = kick_rdata;
                    default: act = {30'b0, stage2_rst, stage1_irq};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    // driver tasks: each starts just after a rising edge and uses one cycle
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic cwr(input logic [11:0] a, input logic [31:0] d);
        ctl_wr = 1; ctl_addr = a; ctl_wdata = d;
        step();
        ctl_wr = 0;
    endtask

    task automatic kwr(input logic [11:0] a);
        kick_wr = 1; kick_addr = a;
        step();
        kick_wr = 0;
    endtask

    task automatic crd(input logic [11:0] a, input string r, input logic [31:0] e);
        item_t it;
        it.req = r; it.kind = 0; it.exp = e;
        sb.push_back(it);
        ctl_rd = 1; ctl_addr = a;
        step();
        ctl_rd = 0;
    endtask

    task automatic krd(input logic [11:0] a, input string r, input logic [31:0] e);
        item_t it;
        it.req = r; it.kind = 1; it.exp = e;
        sb.push_back(it);
        kick_rd = 1; kick_addr = a;
        step();
        kick_rd = 0;
    endtask

    // e = {stage2_rst, stage1_irq}
    task automatic pins(input string r, input logic [1:0] e);
        item_t it;
        it.req = r; it.kind = 2; it.exp = {30'b0, e};
        sb.push_back(it);
        pin_chk = 1;
        step();
        pin_chk = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();

        // R1: reset state
        crd(12'h000, "R1 ctrl", 32'h0);
        crd(12'h008, "R1 period", 32'h0);
        crd(12'h010, "R1 dl_lo", 32'h0);
        crd(12'h014, "R1 dl_hi", 32'h0);
        pins("R1 pins", 2'b00);

        // R9: identification words, both frames
        crd(12'hFCC, "R9 ctl impl", IMPL);
        crd(12'hFD0, "R9 ctl part", PART);
        krd(12'hFCC, "R9 kick impl", IMPL);
        krd(12'hFD0, "R9 kick part", PART);

        // R2: period register
        cwr(12'h008, 32'd100);
        crd(12'h008, "R2 period", 32'd100);

        // R4: enable write refreshes: deadline = 1000 + 100
        sys_cnt = 64'd1000;
        cwr(12'h000, 32'h1);
        crd(12'h000, "R4 ctrl", 32'h1);
        crd(12'h010, "R4 dl_lo", 32'd1100);
        crd(12'h014, "R4 dl_hi", 32'd0);

        // R5: one below the deadline, then exactly on it
        sys_cnt = 64'd1099; step();
        crd(12'h000, "R5 below", 32'h1);
        sys_cnt = 64'd1100; step();
        crd(12'h000, "R5 stage1", 32'h3);
        crd(12'h010, "R5 reload", 32'd1200);
        pins("R7 stage1 pin", 2'b01);

        // R3: kick-frame refresh clears and reloads
        sys_cnt = 64'd1150;
        kwr(12'h000);
        crd(12'h000, "R3 ctrl", 32'h1);
        crd(12'h010, "R3 dl_lo", 32'd1250);
        pins("R3 pins", 2'b00);

        // R6: two expiries in a row
        sys_cnt = 64'd1250; step();
        sys_cnt = 64'd1350; step();
        crd(12'h000, "R6 stage2", 32'h7);
        pins("R7 both pins", 2'b11);
        sys_cnt = 64'd1500; step(); step();
        crd(12'h000, "R6 sticky", 32'h7);

        // R4: control write while both flags set clears them
        sys_cnt = 64'd2000;
        cwr(12'h000, 32'h1);
        crd(12'h000, "R4 clear", 32'h1);
        crd(12'h010, "R4 dl_lo2", 32'd2100);

        // R8: long deadline via direct halves (high half first)
        cwr(12'h014, 32'h1);
        cwr(12'h010, 32'h5);
        crd(12'h010, "R8 dl_lo", 32'h5);
        crd(12'h014, "R8 dl_hi", 32'h1);
        sys_cnt = 64'd3000; step();
        sys_cnt = 64'h1_0000_0004; step();
        crd(12'h000, "R8 long wait", 32'h1);
        sys_cnt = 64'h1_0000_0005; step();
        crd(12'h000, "R5 long expiry", 32'h3);
        crd(12'h010, "R5 long reload lo", 32'h69);
        crd(12'h014, "R5 long reload hi", 32'h1);

        // R8: direct write leaves flags unchanged
        cwr(12'h010, 32'h200);
        crd(12'h000, "R8 flags kept", 32'h3);
        crd(12'h010, "R8 dl_lo3", 32'h200);

        // R10: disable clears and stops checking
        cwr(12'h000, 32'h0);
        crd(12'h000, "R10 off", 32'h0);
        sys_cnt = 64'h2_0000_0000; step(); step();
        crd(12'h000, "R10 no expiry", 32'h0);
        pins("R10 pins", 2'b00);

        // R11: refresh and expiry in the same cycle
        sys_cnt = 64'd5000;
        cwr(12'h000, 32'h1);
        sys_cnt = 64'd5100;
        kwr(12'h000);
        crd(12'h000, "R11 ctrl", 32'h1);
        crd(12'h010, "R11 dl_lo", 32'd5200);

        // R12: unmapped writes and reads
        sys_cnt = 64'd5200; step();
        crd(12'h000, "R12 setup", 32'h3);
        kwr(12'h004);
        crd(12'h000, "R12 kick other", 32'h3);
        cwr(12'h00C, 32'hFFFF_FFFF);
        crd(12'h008, "R12 period kept", 32'd100);
        crd(12'h020, "R12 ctl unmapped", 32'h0);
        krd(12'h000, "R12 kick read", 32'h0);
        pins("R7 stage1 again", 2'b01);

        step();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all-reqs actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule